// File: doc/BRIEF.md
# Colour Matrix Coefficient Encoder

This block turns one colour-conversion matrix coefficient into the 16-bit code that a matrix multiply unit loads into its coefficient register. The coefficient arrives as 64 bits in sign-magnitude form. Bit 63 is the sign. Bits 62:0 are an unsigned magnitude with 32 fraction bits. The output code has four fields: a sign in bit 15, a 3-bit exponent code in bits 14:12, a 9-bit mantissa in bits 11:3, and bits 2:0 held at zero. The 9-bit mantissa window moves with the size of the magnitude, so that small coefficients keep the same relative precision as large ones.

Coefficients enter one at a time on a valid/ready handshake. Each code comes back on a second valid/ready handshake one clock after the input is accepted. When the output is stalled, the block holds its result and accepts no new input.

A second input, sampled with the coefficient, selects limited-range conversion. In that mode a diagonal entry of exactly 1.0 is replaced by the studio-swing gain 219/255 before encoding.

Top module: `csc_coef_encoder`

## Requirements
- R1: Output bit 15 equals input bit 63. The other output bits do not depend on the sign.
- R2: A magnitude of 4.0 or more saturates to 4.0 minus one LSB and encodes as 0x6FF8 in bits 14:0.
- R3: Bits 14:12 carry the exponent code, chosen by magnitude range. Below 0.125 the code is 3 with 12 fraction bits. From 0.125 up to 0.25 the code is 2 with 11 bits. From 0.25 up to 0.5 the code is 1 with 10 bits. From 0.5 up to 1.0 the code is 0 with 9 bits. From 1.0 up to 2.0 the code is 7 with 8 bits. From 2.0 up the code is 6 with 7 bits. Codes 4 and 5 never appear.
- R4: Bits 11:0 are formed as follows. Shift the magnitude right by (29 minus the fraction-bit count). Add 4. Saturate the result at 0xFFF. Clear the three low bits. Bits 2:0 of every code are therefore zero.
- R5: Just below a range boundary, the rounding carry saturates inside the lower range. For example, magnitude 0x1FFFFFFF encodes as 0x3FF8 and magnitude 0xFFFFFFFF encodes as 0x0FF8.
- R6: A magnitude of exactly 1.0 (0x1_0000_0000) encodes as 0x7800.
- R7: With limited-range mode set, a magnitude of exactly 1.0 is replaced by 0xDBDBDBDB (219/255) and encodes as 0x0DC0, with the sign kept. Every other magnitude encodes the same as with the mode clear.
- R8: A zero magnitude encodes as 0x3000. A negative zero encodes as 0xB000.
- R9: An input accepted at a clock edge appears as a valid output, with its code, right after that edge.
- R10: While out_valid is high and out_ready is low, out_code stays unchanged, out_valid stays high and in_ready is low.
- R11: During reset and just after it, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Coefficient present |
| in_ready | output | 1 | Block can take a coefficient |
| in_coef | input | 64 | Sign-magnitude coefficient: bit 63 is the sign, 32 fraction bits |
| in_lr_mode | input | 1 | Limited-range substitution for a unit diagonal entry |
| out_valid | output | 1 | Encoded code present |
| out_ready | input | 1 | Consumer takes the code |
| out_code | output | 16 | Sign, exponent code, mantissa, three zero bits |

## Verification
The handshake assertions assume the consumer drives out_ready freely and that the producer presents in_valid with stable data. They also assume that nothing but reset clears the output register. The stimulus changes inputs only between clock edges and drives out_ready from a pseudo-random pattern, so that both stalls and back-to-back transfers occur.

The encoding assertions assume any 64-bit pattern can arrive, including magnitudes far above 4.0. The stimulus therefore mixes directed boundary values with pseudo-random magnitudes spread across every range and beyond the saturation point.

// File: rtl/csc_enc_pkg.sv
package csc_enc_pkg;

    localparam int COEF_W     = 64;
    localparam int FRAC_W     = 32;
    localparam int INT_W      = 2;
    localparam int CLAMP_W    = FRAC_W + INT_W;
    localparam int EXP_W      = 3;
    localparam int FIELD_W    = 12;
    localparam int GUARD_W    = 3;
    localparam int FB_MAX     = 12;
    localparam int NUM_RANGES = 6;
    localparam int IDX_W      = $clog2(NUM_RANGES);
    localparam int SHIFT_W    = 6;

    typedef enum logic [EXP_W-1:0] {
        EXP_UNDER_EIGHTH  = 3'd3,
        EXP_UNDER_QUARTER = 3'd2,
        EXP_UNDER_HALF    = 3'd1,
        EXP_UNDER_ONE     = 3'd0,
        EXP_UNDER_TWO     = 3'd7,
        EXP_UNDER_FOUR    = 3'd6
    } exp_code_e;

    typedef struct packed {
        logic                neg;
        exp_code_e           exp;
        logic [FIELD_W-1:0]  field;
    } code_t;

    localparam int CODE_W = $bits(code_t);

    function automatic exp_code_e exp_for_range(input logic [IDX_W-1:0] idx);
        case (idx)
            3'd0:    return EXP_UNDER_EIGHTH;
            3'd1:    return EXP_UNDER_QUARTER;
            3'd2:    return EXP_UNDER_HALF;
            3'd3:    return EXP_UNDER_ONE;
            3'd4:    return EXP_UNDER_TWO;
            default: return EXP_UNDER_FOUR;
        endcase
    endfunction

    function automatic logic [63:0] limited_gain(input int frac);
        return (64'd219 << frac) / 64'd255;
    endfunction

endpackage

// File: rtl/csc_mag_prep.sv
module csc_mag_prep
    import csc_enc_pkg::*;
#(
    parameter int P_COEF_W  = COEF_W,
    parameter int P_FRAC_W  = FRAC_W,
    parameter int P_CLAMP_W = CLAMP_W
) (
    input  logic [P_COEF_W-1:0]  coef,
    input  logic                 lr_mode,
    output logic                 neg,
    output logic [P_CLAMP_W-1:0] mag
);
    localparam int RAW_W = P_COEF_W - 1;
    localparam logic [RAW_W-1:0] UNITY_V = RAW_W'(1) << P_FRAC_W;
    localparam logic [RAW_W-1:0] LR_V    = RAW_W'(limited_gain(P_FRAC_W));

    logic [RAW_W-1:0] raw;
    logic [RAW_W-1:0] eff;

    always_comb begin
        raw = coef[RAW_W-1:0];
        neg = coef[P_COEF_W-1];
        eff = (lr_mode && (raw == UNITY_V)) ? LR_V : raw;
        if (|eff[RAW_W-1:P_CLAMP_W]) begin
            mag = '1;
        end else begin
            mag = eff[P_CLAMP_W-1:0];
        end
    end

endmodule

// File: rtl/csc_range_sel.sv
module csc_range_sel
    import csc_enc_pkg::*;
#(
    parameter int P_FRAC_W     = FRAC_W,
    parameter int P_CLAMP_W    = CLAMP_W,
    parameter int P_NUM_RANGES = NUM_RANGES
) (
    input  logic [P_CLAMP_W-1:0] mag,
    output exp_code_e            exp,
    output logic [SHIFT_W-1:0]   shift
);
    localparam int NTH = P_NUM_RANGES - 1;
    localparam int BASE_SHIFT = P_FRAC_W - FB_MAX - GUARD_W;

    logic [NTH-1:0] above;
    logic [IDX_W-1:0] idx;

    for (genvar i = 0; i < NTH; i++) begin : g_thresh
        assign above[i] = mag >= (P_CLAMP_W'(1) << (P_FRAC_W - GUARD_W + i));
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NTH; i++) begin
            idx = idx + IDX_W'(above[i]);
        end
        exp   = exp_for_range(idx);
        shift = SHIFT_W'(BASE_SHIFT) + SHIFT_W'(idx);
    end

endmodule

// File: rtl/csc_mant_round.sv
module csc_mant_round
    import csc_enc_pkg::*;
#(
    parameter int P_CLAMP_W = CLAMP_W,
    parameter int P_FIELD_W = FIELD_W,
    parameter int P_GUARD_W = GUARD_W
) (
    input  logic [P_CLAMP_W-1:0] mag,
    input  logic [SHIFT_W-1:0]   shift,
    output logic [P_FIELD_W-1:0] field
);
    localparam int SUM_W = P_CLAMP_W + 1;
    localparam logic [SUM_W-1:0] ROUND_V = SUM_W'(1) << (P_GUARD_W - 1);
    localparam logic [SUM_W-1:0] FULL_V  = SUM_W'((1 << P_FIELD_W) - 1);

    logic [P_CLAMP_W-1:0] shifted;
    logic [SUM_W-1:0]     sum;
    logic [P_FIELD_W-1:0] sat;

    always_comb begin
        shifted = mag >> shift;
        sum     = {1'b0, shifted} + ROUND_V;
        sat     = (sum > FULL_V) ? FULL_V[P_FIELD_W-1:0] : sum[P_FIELD_W-1:0];
        field   = {sat[P_FIELD_W-1:P_GUARD_W], {P_GUARD_W{1'b0}}};
    end

endmodule

// File: rtl/csc_out_reg.sv
module csc_out_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= in_data;
            end
        end
    end

    a_r9_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

    a_r9_data_taken: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_data == $past(in_data)));

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r10_no_accept: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: rtl/csc_coef_encoder.sv
module csc_coef_encoder
    import csc_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [COEF_W-1:0] in_coef,
    input  logic              in_lr_mode,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [CODE_W-1:0] out_code
);
    logic               neg;
    logic [CLAMP_W-1:0] mag;
    exp_code_e          exp;
    logic [SHIFT_W-1:0] shift;
    logic [FIELD_W-1:0] field;
    code_t              code_next;

    csc_mag_prep u_prep (
        .coef    (in_coef),
        .lr_mode (in_lr_mode),
        .neg     (neg),
        .mag     (mag)
    );

    csc_range_sel u_range (
        .mag   (mag),
        .exp   (exp),
        .shift (shift)
    );

    csc_mant_round u_round (
        .mag   (mag),
        .shift (shift),
        .field (field)
    );

    always_comb begin
        code_next.neg   = neg;
        code_next.exp   = exp;
        code_next.field = field;
    end

    csc_out_reg #(.W(CODE_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (code_next),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_code)
    );

    a_r1_sign_follows: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (out_code[15] == $past(in_coef[63])));

    a_r3_legal_exp: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_code[14:12] != 3'd4 && out_code[14:12] != 3'd5));

    a_r4_guard_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_code[2:0] == 3'b000));

    a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && (in_coef[62:34] != '0)) |=> (out_code[14:0] == 15'h6FF8));

endmodule

// File: tb/csc_coef_encoder_tb.sv
module csc_coef_encoder_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_coef = '0;
    logic        in_lr_mode = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_code;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        ready_rand = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [63:0] xs = 64'h9E3779B97F4A7C15;
    logic        held = 1'b0;
    logic [15:0] held_code = '0;
    logic        done = 1'b0;

    csc_coef_encoder u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_coef(in_coef), .in_lr_mode(in_lr_mode), .out_valid(out_valid),
        .out_ready(out_ready), .out_code(out_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] model(input logic [63:0] c, input logic lr);
        longint unsigned m;
        longint unsigned v;
        int fb;
        logic [2:0] e;
        m = {1'b0, c[62:0]};
        if (lr && m == 64'h1_0000_0000) m = 64'hDBDBDBDB;
        if (m > 64'h3_FFFF_FFFF) m = 64'h3_FFFF_FFFF;
        if (m < 64'h2000_0000)      begin fb = 12; e = 3'd3; end
        else if (m < 64'h4000_0000) begin fb = 11; e = 3'd2; end
        else if (m < 64'h8000_0000) begin fb = 10; e = 3'd1; end
        else if (m < 64'h1_0000_0000) begin fb = 9; e = 3'd0; end
        else if (m < 64'h2_0000_0000) begin fb = 8; e = 3'd7; end
        else begin fb = 7; e = 3'd6; end
        v = (m >> (29 - fb)) + 64'd4;
        if (v > 64'hFFF) v = 64'hFFF;
        v = v & 64'hFF8;
        return {c[63], e, v[11:0]};
    endfunction

    task automatic send(input logic [63:0] c, input logic lr, input logic [15:0] expv, input string tag);
        @(posedge clk); #1;
        in_valid = 1'b1; in_coef = c; in_lr_mode = lr;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        in_valid = 1'b0;
        @(negedge clk);
        // R9: output valid with this item right after the accepting edge
        check(out_valid === 1'b1 && out_code === expv, {"R9 ", tag}, out_code, expv);
    endtask

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = ready_rand ? lfsr[0] : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (held) begin
                check(out_valid === 1'b1 && out_code === held_code, "R10 hold", out_code, held_code);
            end
            held = out_valid && !out_ready;
            held_code = out_code;
            if (held) check(in_ready === 1'b0, "R10 in_ready", {15'd0, in_ready}, 16'd0);
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected output", out_code, 16'hxxxx);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(out_code === e, t, out_code, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R11: reset state
        check(out_valid === 1'b0 && in_ready === 1'b1, "R11 in reset", {14'd0, out_valid, in_ready}, 16'h0001);
        @(posedge clk); #1; rst = 1'b0;
        @(negedge clk);
        check(out_valid === 1'b0 && in_ready === 1'b1, "R11 after reset", {14'd0, out_valid, in_ready}, 16'h0001);

        send(64'h0, 1'b0, 16'h3000, "R8 zero");
        send(64'h8000_0000_0000_0000, 1'b0, 16'hB000, "R8 negative zero");
        send(64'h1_0000_0000, 1'b0, 16'h7800, "R6 unity");
        send(64'h8000_0001_0000_0000, 1'b0, 16'hF800, "R1 negative unity");
        send(64'h8000_0000, 1'b0, 16'h0800, "R3 half");
        send(64'h4000_0000, 1'b0, 16'h1800, "R3 quarter");
        send(64'h2000_0000, 1'b0, 16'h2800, "R3 eighth");
        send(64'h2_0000_0000, 1'b0, 16'h6800, "R3 two");
        send(64'h1FFF_FFFF, 1'b0, 16'h3FF8, "R5 below eighth");
        send(64'hFFFF_FFFF, 1'b0, 16'h0FF8, "R5 below one");
        send(64'h3_FFFF_FFFF, 1'b0, 16'h6FF8, "R2 max in range");
        send(64'hA_0000_0000, 1'b0, 16'h6FF8, "R2 ten saturates");
        send(64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 16'hEFF8, "R2 huge negative");
        send(64'h1_0000_0000, 1'b1, 16'h0DC0, "R7 limited unity");
        send(64'h8000_0001_0000_0000, 1'b1, 16'h8DC0, "R7 limited negative unity");
        send(64'h8000_0000, 1'b1, 16'h0800, "R7 lr ignores half");
        send(64'h1_0000_0001, 1'b1, model(64'h1_0000_0001, 1'b0), "R7 lr ignores near unity");
        send(64'h0123_4567, 1'b0, model(64'h0123_4567, 1'b0), "R4 small value");

        ready_rand = 1'b1;
        for (int k = 0; k < 60; k++) begin
            logic [63:0] c;
            xs = xs ^ (xs << 13); xs = xs ^ (xs >> 7); xs = xs ^ (xs << 17);
            c = {xs[63], xs[62:0] >> (xs[5:0] % 6'd40 + 6'd20)};
            send(c, xs[7], model(c, xs[7]), "R3 R4 random");
        end

        ready_rand = 1'b0;
        for (int k = 0; k < 50 && exp_q.size() != 0; k++) @(negedge clk);
        check(exp_q.size() == 0, "R9 drained", 16'(exp_q.size()), 16'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule